// File: doc/BRIEF.md
# 24-bit Effective Address Generator

This block forms the memory addresses used by a 16-bit-capable 6502-family processor core for every operand addressing mode it supports. The sequencer presents a mode code, the instruction's operand bytes, the bank, page and stack registers, the two index registers and the index-width flag. For pointer-based modes it also presents the pointer bytes it has already fetched. The block answers in the same cycle, because it contains no storage.

The generator has three address outputs. The main output is the final effective address. A second output gives the place a pointer must be read from, for modes that go through memory. For block moves, a third output gives the destination address, and a separate output gives the transfer length. The fetch ordering, cycle counts and penalty cycles all stay in the sequencer that drives this block.

Indexing works on the full 24-bit address, so an index can carry into the bank byte. Sums built on the direct page register or the stack pointer stay inside bank zero and wrap at 16 bits.

Top module: `eag_addr_gen`

## Requirements
- R1: Mode 0 (data absolute) gives `ea_o = {dbank_i, op1_i, op0_i}`. Mode 1 (control absolute) gives `{pbank_i, op1_i, op0_i}`.
- R2: Mode 2 adds the effective X to `{dbank_i, op1_i, op0_i}` modulo 2^24, and mode 3 adds the effective Y in the same way. The carry propagates into the bank byte.
- R3: Mode 4 gives `{op2_i, op1_i, op0_i}`. Mode 5 adds the effective X to that value modulo 2^24.
- R4: Modes 6, 7 and 8 give an address in bank zero. The address is `dpage_i + op0_i` for mode 6, plus the effective X for mode 7 and plus the effective Y for mode 8. The sum wraps modulo 2^16.
- R5: Modes 9 and 10 read their pointer at bank zero. For mode 9 the pointer sits at `dpage_i + op0_i`. For mode 10 it sits at that sum plus the effective X, wrapped to 16 bits. For both modes `ea_o = {dbank_i, ptr_hi_i, ptr_lo_i}`.
- R6: Modes 11, 12 and 13 read their pointer at bank zero, at `dpage_i + op0_i`. Mode 11 gives `{dbank_i, ptr_hi_i, ptr_lo_i}` plus the effective Y. Mode 12 gives `{ptr_bank_i, ptr_hi_i, ptr_lo_i}`, and mode 13 gives that value plus the effective Y. Each sum wraps modulo 2^24.
- R7: Mode 14 gives bank zero at `sp_i + op0_i`, wrapped to 16 bits. Mode 15 reads its pointer at that same bank-zero location and gives `{dbank_i, ptr_hi_i, ptr_lo_i}` plus the effective Y, modulo 2^24.
- R8: Mode 16 reads its pointer at bank zero, at `{op1_i, op0_i}`, and targets `{pbank_i, ptr_hi_i, ptr_lo_i}`. Mode 17 reads its pointer in the program bank, at `{op1_i, op0_i}` plus the effective X wrapped to 16 bits, and targets the same form as mode 16. Mode 18 reads its pointer at bank zero, at `{op1_i, op0_i}`, and targets `{ptr_bank_i, ptr_hi_i, ptr_lo_i}`.
- R9: Mode 19 (block move) gives a source of `{op1_i, effective X}` on `ea_o` and a destination of `{op0_i, effective Y}` on `ea_dst_o`. It also gives `move_count_o = acc_i + 1` as a 17-bit value, so an accumulator of 0xFFFF yields 0x10000. In every other mode `ea_dst_o` and `move_count_o` are zero.
- R10: `uses_ptr_o` is 1 exactly for modes 9 to 13 and 15 to 18, and `ptr_addr_o` is zero whenever `uses_ptr_o` is 0. Mode codes 20 to 31 drive all outputs to zero.
- R11: When `idx8_i` is 1, the effective X and Y are the low byte of the register with a zero high byte. When `idx8_i` is 0, they are the full 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 5 | Addressing mode code |
| op0_i | input | 8 | First operand byte |
| op1_i | input | 8 | Second operand byte |
| op2_i | input | 8 | Third operand byte |
| dbank_i | input | 8 | Data bank register |
| pbank_i | input | 8 | Program bank register |
| dpage_i | input | 16 | Direct page register |
| sp_i | input | 16 | Stack pointer |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| idx8_i | input | 1 | Index registers are 8 bits wide |
| acc_i | input | 16 | 16-bit accumulator (block-move length minus one) |
| ptr_lo_i | input | 8 | Fetched pointer low byte |
| ptr_hi_i | input | 8 | Fetched pointer high byte |
| ptr_bank_i | input | 8 | Fetched pointer bank byte (long pointers) |
| ea_o | output | 24 | Effective address, or block-move source |
| ea_dst_o | output | 24 | Block-move destination |
| ptr_addr_o | output | 24 | Address of the pointer to fetch |
| uses_ptr_o | output | 1 | Mode reads a pointer from memory |
| move_count_o | output | 17 | Block-move byte count |

## Verification
The bench builds the block with its default widths: an 8-bit bank, a 16-bit offset and a 24-bit address. These widths let a directed case carry an index out of 0xFFFFFF into zero, and let another carry an absolute-indexed sum across a bank boundary. The same widths let direct-page, stack and jump-table sums wrap at 0xFFFF while the bank stays fixed. Random vectors cover all 32 mode codes, so the 12 unused codes are exercised too, with both index widths.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int BANK_W = 8;
    localparam int OFS_W  = 16;
    localparam int ADDR_W = BANK_W + OFS_W;
    localparam int MODE_W = 5;
    localparam int CNT_W  = OFS_W + 1;

    typedef enum logic [MODE_W-1:0] {
        M_ABS_DATA     = 5'd0,
        M_ABS_CTRL     = 5'd1,
        M_ABS_X        = 5'd2,
        M_ABS_Y        = 5'd3,
        M_LONG         = 5'd4,
        M_LONG_X       = 5'd5,
        M_DP           = 5'd6,
        M_DP_X         = 5'd7,
        M_DP_Y         = 5'd8,
        M_DP_IND       = 5'd9,
        M_DP_X_IND     = 5'd10,
        M_DP_IND_Y     = 5'd11,
        M_DP_IND_L     = 5'd12,
        M_DP_IND_L_Y   = 5'd13,
        M_STK          = 5'd14,
        M_STK_IND_Y    = 5'd15,
        M_JMP_IND      = 5'd16,
        M_JMP_X_IND    = 5'd17,
        M_JMP_IND_L    = 5'd18,
        M_MOVE         = 5'd19
    } mode_e;

    typedef enum logic [1:0] { IX_NONE, IX_X, IX_Y } idx_sel_e;
    typedef enum logic [1:0] { PG_DIRECT, PG_STACK, PG_OPWORD } page_base_e;
    typedef enum logic [1:0] { BK_DATA, BK_PROG, BK_ZERO } bank_sel_e;
    typedef enum logic [2:0] {
        EA_NONE, EA_OPER16, EA_OPER24, EA_PAGE, EA_PTR16, EA_PTR24, EA_MOVE
    } ea_src_e;

    typedef struct packed {
        page_base_e pg_base;
        idx_sel_e   pg_idx;
        logic       ptr_used;
        bank_sel_e  ptr_bank;
        ea_src_e    ea_src;
        bank_sel_e  ea_bank;
        idx_sel_e   ea_idx;
        logic       is_move;
    } route_t;

    function automatic route_t route_of(logic [MODE_W-1:0] code);
        route_t r;
        r = '{pg_base: PG_DIRECT, pg_idx: IX_NONE, ptr_used: 1'b0,
              ptr_bank: BK_ZERO, ea_src: EA_NONE, ea_bank: BK_DATA,
              ea_idx: IX_NONE, is_move: 1'b0};
        case (code)
            M_ABS_DATA:   r.ea_src = EA_OPER16;
            M_ABS_CTRL: begin r.ea_src = EA_OPER16; r.ea_bank = BK_PROG; end
            M_ABS_X:    begin r.ea_src = EA_OPER16; r.ea_idx = IX_X; end
            M_ABS_Y:    begin r.ea_src = EA_OPER16; r.ea_idx = IX_Y; end
            M_LONG:       r.ea_src = EA_OPER24;
            M_LONG_X:   begin r.ea_src = EA_OPER24; r.ea_idx = IX_X; end
            M_DP:         r.ea_src = EA_PAGE;
            M_DP_X:     begin r.ea_src = EA_PAGE; r.pg_idx = IX_X; end
            M_DP_Y:     begin r.ea_src = EA_PAGE; r.pg_idx = IX_Y; end
            M_DP_IND:   begin r.ptr_used = 1'b1; r.ea_src = EA_PTR16; end
            M_DP_X_IND: begin
                r.ptr_used = 1'b1; r.pg_idx = IX_X; r.ea_src = EA_PTR16;
            end
            M_DP_IND_Y: begin
                r.ptr_used = 1'b1; r.ea_src = EA_PTR16; r.ea_idx = IX_Y;
            end
            M_DP_IND_L: begin r.ptr_used = 1'b1; r.ea_src = EA_PTR24; end
            M_DP_IND_L_Y: begin
                r.ptr_used = 1'b1; r.ea_src = EA_PTR24; r.ea_idx = IX_Y;
            end
            M_STK:      begin r.pg_base = PG_STACK; r.ea_src = EA_PAGE; end
            M_STK_IND_Y: begin
                r.pg_base = PG_STACK; r.ptr_used = 1'b1;
                r.ea_src = EA_PTR16; r.ea_idx = IX_Y;
            end
            M_JMP_IND: begin
                r.pg_base = PG_OPWORD; r.ptr_used = 1'b1;
                r.ea_src = EA_PTR16; r.ea_bank = BK_PROG;
            end
            M_JMP_X_IND: begin
                r.pg_base = PG_OPWORD; r.pg_idx = IX_X; r.ptr_used = 1'b1;
                r.ptr_bank = BK_PROG; r.ea_src = EA_PTR16; r.ea_bank = BK_PROG;
            end
            M_JMP_IND_L: begin
                r.pg_base = PG_OPWORD; r.ptr_used = 1'b1; r.ea_src = EA_PTR24;
            end
            M_MOVE:     begin r.ea_src = EA_MOVE; r.is_move = 1'b1; end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eag_idx_trim.sv
module eag_idx_trim #(
    parameter int W    = 16,
    parameter int KEEP = 8
) (
    input  logic [W-1:0] raw_i,
    input  logic         narrow_i,
    output logic [W-1:0] eff_o
);
    localparam int DROP = W - KEEP;

    assign eff_o = narrow_i ? {{DROP{1'b0}}, raw_i[KEEP-1:0]} : raw_i;
endmodule

// File: rtl/eag_wrap_add.sv
module eag_wrap_add #(
    parameter int W = 24
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    assign sum_o = a_i + b_i;
endmodule

// File: rtl/eag_addr_gen.sv
module eag_addr_gen
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [BANK_W-1:0] op0_i,
    input  logic [BANK_W-1:0] op1_i,
    input  logic [BANK_W-1:0] op2_i,
    input  logic [BANK_W-1:0] dbank_i,
    input  logic [BANK_W-1:0] pbank_i,
    input  logic [OFS_W-1:0]  dpage_i,
    input  logic [OFS_W-1:0]  sp_i,
    input  logic [OFS_W-1:0]  x_i,
    input  logic [OFS_W-1:0]  y_i,
    input  logic              idx8_i,
    input  logic [OFS_W-1:0]  acc_i,
    input  logic [BANK_W-1:0] ptr_lo_i,
    input  logic [BANK_W-1:0] ptr_hi_i,
    input  logic [BANK_W-1:0] ptr_bank_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] ea_dst_o,
    output logic [ADDR_W-1:0] ptr_addr_o,
    output logic              uses_ptr_o,
    output logic [CNT_W-1:0]  move_count_o
);
    localparam int N_IDX = 2;

    route_t route;
    assign route = route_of(mode_i);

    // index width trimming, one instance per index register
    logic [OFS_W-1:0] idx_raw [N_IDX];
    logic [OFS_W-1:0] idx_eff [N_IDX];
    assign idx_raw[0] = x_i;
    assign idx_raw[1] = y_i;

    for (genvar g = 0; g < N_IDX; g++) begin : g_trim
        eag_idx_trim #(.W(OFS_W), .KEEP(BANK_W)) u_trim (
            .raw_i    (idx_raw[g]),
            .narrow_i (idx8_i),
            .eff_o    (idx_eff[g])
        );
    end

    function automatic logic [OFS_W-1:0] pick_idx(idx_sel_e s,
                                                 logic [OFS_W-1:0] xv,
                                                 logic [OFS_W-1:0] yv);
        case (s)
            IX_X:    return xv;
            IX_Y:    return yv;
            default: return '0;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] pick_bank(bank_sel_e s,
                                                   logic [BANK_W-1:0] db,
                                                   logic [BANK_W-1:0] pb);
        case (s)
            BK_DATA: return db;
            BK_PROG: return pb;
            default: return '0;
        endcase
    endfunction

    // 16-bit in-bank sum: base + byte offset + index
    logic [OFS_W-1:0] pg_a, pg_b, pg_c, pg_mid, pg_sum;

    always_comb begin
        case (route.pg_base)
            PG_STACK:  pg_a = sp_i;
            PG_OPWORD: pg_a = {op1_i, op0_i};
            default:   pg_a = dpage_i;
        endcase
        pg_b = (route.pg_base == PG_OPWORD) ? '0 : OFS_W'(op0_i);
        pg_c = pick_idx(route.pg_idx, idx_eff[0], idx_eff[1]);
    end

    eag_wrap_add #(.W(OFS_W)) u_pg_add0 (.a_i(pg_a),   .b_i(pg_b), .sum_o(pg_mid));
    eag_wrap_add #(.W(OFS_W)) u_pg_add1 (.a_i(pg_mid), .b_i(pg_c), .sum_o(pg_sum));

    // 24-bit base plus index
    logic [ADDR_W-1:0] ea_base, ea_addend, ea_sum;
    logic [BANK_W-1:0] ea_bank;

    always_comb begin
        ea_bank = pick_bank(route.ea_bank, dbank_i, pbank_i);
        case (route.ea_src)
            EA_OPER16: ea_base = {ea_bank, op1_i, op0_i};
            EA_OPER24: ea_base = {op2_i, op1_i, op0_i};
            EA_PAGE:   ea_base = {{BANK_W{1'b0}}, pg_sum};
            EA_PTR16:  ea_base = {ea_bank, ptr_hi_i, ptr_lo_i};
            EA_PTR24:  ea_base = {ptr_bank_i, ptr_hi_i, ptr_lo_i};
            EA_MOVE:   ea_base = {op1_i, idx_eff[0]};
            default:   ea_base = '0;
        endcase
        ea_addend = ADDR_W'(pick_idx(route.ea_idx, idx_eff[0], idx_eff[1]));
    end

    eag_wrap_add #(.W(ADDR_W)) u_ea_add (.a_i(ea_base), .b_i(ea_addend), .sum_o(ea_sum));

    assign ea_o       = ea_sum;
    assign uses_ptr_o = route.ptr_used;
    assign ptr_addr_o = route.ptr_used
                      ? {pick_bank(route.ptr_bank, dbank_i, pbank_i), pg_sum}
                      : '0;
    assign ea_dst_o     = route.is_move ? {op0_i, idx_eff[1]} : '0;
    assign move_count_o = route.is_move ? ({1'b0, acc_i} + CNT_W'(1)) : '0;

endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [BANK_W-1:0] op0_i,
    input  logic [BANK_W-1:0] op1_i,
    input  logic [BANK_W-1:0] op2_i,
    input  logic [BANK_W-1:0] dbank_i,
    input  logic [BANK_W-1:0] pbank_i,
    input  logic [OFS_W-1:0]  dpage_i,
    input  logic [OFS_W-1:0]  sp_i,
    input  logic [OFS_W-1:0]  x_i,
    input  logic [OFS_W-1:0]  y_i,
    input  logic              idx8_i,
    input  logic [OFS_W-1:0]  acc_i,
    input  logic [BANK_W-1:0] ptr_lo_i,
    input  logic [BANK_W-1:0] ptr_hi_i,
    input  logic [BANK_W-1:0] ptr_bank_i,
    input  logic [ADDR_W-1:0] ea_o,
    input  logic [ADDR_W-1:0] ea_dst_o,
    input  logic [ADDR_W-1:0] ptr_addr_o,
    input  logic              uses_ptr_o,
    input  logic [CNT_W-1:0]  move_count_o
);
    always_comb begin
        if (mode_i == M_ABS_DATA || mode_i == M_ABS_CTRL)
            assert_abs_low_word_R1: assert (ea_o[OFS_W-1:0] == {op1_i, op0_i})
                else $error("absolute low word mismatch");

        if (mode_i == M_LONG)
            assert_long_operand_R3: assert (ea_o == {op2_i, op1_i, op0_i})
                else $error("long address mismatch");

        if (mode_i == M_DP || mode_i == M_DP_X || mode_i == M_DP_Y || mode_i == M_STK)
            assert_page_bank_zero_R4: assert (ea_o[ADDR_W-1:OFS_W] == '0)
                else $error("page address left bank zero");

        if (uses_ptr_o && mode_i != M_JMP_X_IND)
            assert_ptr_bank_zero_R5: assert (ptr_addr_o[ADDR_W-1:OFS_W] == '0)
                else $error("pointer not in bank zero");

        if (mode_i == M_JMP_X_IND)
            assert_ptr_prog_bank_R8: assert (ptr_addr_o[ADDR_W-1:OFS_W] == pbank_i)
                else $error("indexed jump pointer outside program bank");

        if (mode_i == M_MOVE && idx8_i)
            assert_move_high_zero_R11: assert (ea_o[OFS_W-1:BANK_W] == '0 &&
                                               ea_dst_o[OFS_W-1:BANK_W] == '0)
                else $error("narrow index leaked a high byte");

        if (mode_i == M_MOVE)
            assert_move_count_nonzero_R9: assert (move_count_o != '0)
                else $error("block count zero");

        if (mode_i > M_MOVE)
            assert_unused_quiet_R10: assert (!uses_ptr_o && ea_o == '0 &&
                                             ea_dst_o == '0 && ptr_addr_o == '0)
                else $error("unused mode drove an output");

        if (!uses_ptr_o)
            assert_no_ptr_addr_R10: assert (ptr_addr_o == '0)
                else $error("pointer address without pointer mode");
    end
endmodule

bind eag_addr_gen eag_checker u_eag_checker (.*);

// File: tb/eag_addr_gen_test.sv
module eag_addr_gen_test;
    import eag_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [4:0]  mode_i;
    logic [7:0]  op0_i, op1_i, op2_i, dbank_i, pbank_i;
    logic [15:0] dpage_i, sp_i, x_i, y_i, acc_i;
    logic        idx8_i;
    logic [7:0]  ptr_lo_i, ptr_hi_i, ptr_bank_i;
    logic [23:0] ea_o, ea_dst_o, ptr_addr_o;
    logic        uses_ptr_o;
    logic [16:0] move_count_o;

    eag_addr_gen uut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic [23:0] ea;
        logic [23:0] dst;
        logic [23:0] ptr;
        logic        up;
        logic [16:0] cnt;
    } exp_t;

    function automatic string tag_of(int m);
        if (m <= 1) return "R1";
        if (m <= 3) return "R2";
        if (m <= 5) return "R3";
        if (m <= 8) return "R4";
        if (m <= 10) return "R5";
        if (m <= 13) return "R6";
        if (m <= 15) return "R7";
        if (m <= 18) return "R8";
        if (m == 19) return "R9";
        return "R10";
    endfunction

    function automatic exp_t model();
        exp_t e;
        logic [15:0] xe, ye, dsum;
        logic [23:0] d16ptr;
        xe = idx8_i ? {8'h00, x_i[7:0]} : x_i;   // R11
        ye = idx8_i ? {8'h00, y_i[7:0]} : y_i;
        dsum = dpage_i + {8'h00, op0_i};
        d16ptr = {dbank_i, ptr_hi_i, ptr_lo_i};
        e = '0;
        case (int'(mode_i))
            0:  e.ea = {dbank_i, op1_i, op0_i};
            1:  e.ea = {pbank_i, op1_i, op0_i};
            2:  e.ea = {dbank_i, op1_i, op0_i} + {8'h00, xe};
            3:  e.ea = {dbank_i, op1_i, op0_i} + {8'h00, ye};
            4:  e.ea = {op2_i, op1_i, op0_i};
            5:  e.ea = {op2_i, op1_i, op0_i} + {8'h00, xe};
            6:  e.ea = {8'h00, dsum};
            7:  e.ea = {8'h00, 16'(dsum + xe)};
            8:  e.ea = {8'h00, 16'(dsum + ye)};
            9:  begin e.up = 1; e.ptr = {8'h00, dsum}; e.ea = d16ptr; end
            10: begin e.up = 1; e.ptr = {8'h00, 16'(dsum + xe)}; e.ea = d16ptr; end
            11: begin e.up = 1; e.ptr = {8'h00, dsum}; e.ea = d16ptr + {8'h00, ye}; end
            12: begin e.up = 1; e.ptr = {8'h00, dsum}; e.ea = {ptr_bank_i, ptr_hi_i, ptr_lo_i}; end
            13: begin
                e.up = 1; e.ptr = {8'h00, dsum};
                e.ea = {ptr_bank_i, ptr_hi_i, ptr_lo_i} + {8'h00, ye};
            end
            14: e.ea = {8'h00, 16'(sp_i + {8'h00, op0_i})};
            15: begin
                e.up = 1; e.ptr = {8'h00, 16'(sp_i + {8'h00, op0_i})};
                e.ea = d16ptr + {8'h00, ye};
            end
            16: begin e.up = 1; e.ptr = {8'h00, op1_i, op0_i}; e.ea = {pbank_i, ptr_hi_i, ptr_lo_i}; end
            17: begin
                e.up = 1; e.ptr = {pbank_i, 16'({op1_i, op0_i} + xe)};
                e.ea = {pbank_i, ptr_hi_i, ptr_lo_i};
            end
            18: begin e.up = 1; e.ptr = {8'h00, op1_i, op0_i}; e.ea = {ptr_bank_i, ptr_hi_i, ptr_lo_i}; end
            19: begin
                e.ea = {op1_i, xe}; e.dst = {op0_i, ye};
                e.cnt = {1'b0, acc_i} + 17'd1;
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic check(string tag);
        exp_t e;
        exp_t a;
        e = model();
        a = '{ea: ea_o, dst: ea_dst_o, ptr: ptr_addr_o, up: uses_ptr_o, cnt: move_count_o};
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s mode=%0d actual ea=%h dst=%h ptr=%h up=%b cnt=%h expected ea=%h dst=%h ptr=%h up=%b cnt=%h",
                     tag, mode_i, a.ea, a.dst, a.ptr, a.up, a.cnt,
                     e.ea, e.dst, e.ptr, e.up, e.cnt);
        end
    endtask

    task automatic clear_inputs();
        mode_i = 0; op0_i = 0; op1_i = 0; op2_i = 0; dbank_i = 0; pbank_i = 0;
        dpage_i = 0; sp_i = 0; x_i = 0; y_i = 0; acc_i = 0; idx8_i = 0;
        ptr_lo_i = 0; ptr_hi_i = 0; ptr_bank_i = 0;
    endtask

    task automatic apply_and_check(string tag);
        @(negedge clk);
        #1;
        check(tag);
    endtask

    task automatic expect_ea(string tag, logic [23:0] want);
        checks++;
        if (ea_o !== want) begin
            fails++;
            $display("FAIL %s actual ea=%h expected ea=%h", tag, ea_o, want);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        int seed;
        seed = 32'h5EED_0A1B;
        void'($urandom(seed));
        clear_inputs();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state: all-zero inputs give a zero data-absolute address (R1)
        @(negedge clk); #1;
        expect_ea("R1 reset", 24'h000000);
        check("R10 reset");

        // R2: index carries into the bank byte
        clear_inputs(); mode_i = 2; dbank_i = 8'h12; op1_i = 8'hFF; op0_i = 8'hF0; x_i = 16'h0020;
        apply_and_check("R2");
        expect_ea("R2 bank carry", 24'h130010);

        // R11: narrow index keeps only the low byte
        clear_inputs(); mode_i = 3; dbank_i = 8'h01; y_i = 16'hABCD; idx8_i = 1;
        apply_and_check("R11");
        expect_ea("R11 narrow Y", 24'h0100CD);

        // R3: long indexed wraps at 2^24
        clear_inputs(); mode_i = 5; op2_i = 8'hFF; op1_i = 8'hFF; op0_i = 8'hFF; x_i = 16'h0001;
        apply_and_check("R3");
        expect_ea("R3 wrap", 24'h000000);

        // R4: direct page wraps in bank zero
        clear_inputs(); mode_i = 7; dpage_i = 16'hFFF0; op0_i = 8'h20; x_i = 16'h0005; dbank_i = 8'h7E;
        apply_and_check("R4");
        expect_ea("R4 page wrap", 24'h000015);

        // R5: indexed pointer location wraps, data bank prefixes pointer
        clear_inputs(); mode_i = 10; dpage_i = 16'hFFFF; op0_i = 8'h01; x_i = 16'h0002;
        dbank_i = 8'h33; ptr_hi_i = 8'h44; ptr_lo_i = 8'h55;
        apply_and_check("R5");
        expect_ea("R5 ptr target", 24'h334455);

        // R6: long pointer plus Y carries past the top
        clear_inputs(); mode_i = 13; ptr_bank_i = 8'hFF; ptr_hi_i = 8'hFF; ptr_lo_i = 8'hF0; y_i = 16'h0020;
        apply_and_check("R6");
        expect_ea("R6 long ptr wrap", 24'h000010);

        // R7: stack relative wraps at 16 bits
        clear_inputs(); mode_i = 15; sp_i = 16'hFFFE; op0_i = 8'h04; dbank_i = 8'h02;
        ptr_hi_i = 8'h10; ptr_lo_i = 8'h00; y_i = 16'h0003;
        apply_and_check("R7");
        expect_ea("R7 target", 24'h021003);

        // R8: indexed jump pointer stays in program bank
        clear_inputs(); mode_i = 17; pbank_i = 8'h80; op1_i = 8'hFF; op0_i = 8'hFE; x_i = 16'h0004;
        ptr_hi_i = 8'h12; ptr_lo_i = 8'h34;
        apply_and_check("R8");
        expect_ea("R8 target", 24'h801234);

        // R9: full-length block move
        clear_inputs(); mode_i = 19; op1_i = 8'h7E; op0_i = 8'h7F; x_i = 16'h1234; y_i = 16'h5678; acc_i = 16'hFFFF;
        apply_and_check("R9");
        checks++;
        if (move_count_o !== 17'h10000) begin
            fails++;
            $display("FAIL R9 actual count=%h expected count=%h", move_count_o, 17'h10000);
        end

        // R10: an unused code
        clear_inputs(); mode_i = 25; op0_i = 8'hAA; x_i = 16'hFFFF; acc_i = 16'h0010;
        apply_and_check("R10");

        // constrained random across every code and both index widths
        for (int i = 0; i < 3000; i++) begin
            mode_i     = 5'($urandom_range(0, 31));
            op0_i      = 8'($urandom);   op1_i = 8'($urandom); op2_i = 8'($urandom);
            dbank_i    = 8'($urandom);   pbank_i = 8'($urandom);
            dpage_i    = 16'($urandom);  sp_i = 16'($urandom);
            x_i        = 16'($urandom);  y_i = 16'($urandom);  acc_i = 16'($urandom);
            idx8_i     = 1'($urandom);
            ptr_lo_i   = 8'($urandom);   ptr_hi_i = 8'($urandom); ptr_bank_i = 8'($urandom);
            if ((i % 8) == 0) begin
                dpage_i = 16'hFFF8 | 16'(i[2:0]);
                x_i = 16'hFFC0 | 16'(i[5:0]);
            end
            apply_and_check(idx8_i ? "R11" : tag_of(int'(mode_i)));
        end

        finish_run();
    end
endmodule